// File: doc/BRIEF.md
# Kernel Launch and Completion Interrupt Controller

This block sits between a host processor and an array of reconfigurable datapath units. The host programs it with ordinary bus writes (16-bit address, 32-bit data). Writing the start register fires single-cycle start requests toward the units. The block latches the acknowledgements and port handshakes that come back, and uses them to decide when each kernel slot has finished. A slot finishes when every acknowledgement in its mask has arrived and, if it has a port mask, at least one of those port handshakes has also arrived.

Finished slots become pending. Pending slots that are enabled raise a registered fast interrupt. In priority mode any enabled pending slot raises it, and the lowest slot number is the one reported. In parallel mode the interrupt waits until no enabled slot is still armed. Any interrupt request also clears the host sleep flag, which wakes the host.

A typical host sequence is: clear the sticky handshake status, program the masks and enables, arm the slots and pulse the starts, set sleep, and then service the interrupt when it arrives.

Top module: `kernel_irq_ctrl`

## Requirements
- R1: After reset, start_o, fiq_o and sleep_o are 0, and every readable register reads 0.
- R2: Writing START (0x08) with bits [N_SLOT-1:0] set drives those bits on start_o for exactly one cycle after the write edge. START bits [16+k] arm kernel k.
- R3: Each ack_i and port_hs_i bit is latched into a sticky status bit. Acks read at ACK_STS (0x10) and ports at PORT_STS (0x14). Writing 1 to a bit of either register clears it, and a new arrival in the same cycle wins over the clear.
- R4: Each kernel k has an ack mask at 0x40+8k and a port mask at 0x44+8k. An armed kernel completes when all of its masked sticky acks are set and either its port mask is 0 or some masked sticky port is set. Completion sets pending bit k at PEND (0x18) bits [N_KERN-1:0] on the next edge and disarms the kernel. Writing 1 to PEND bit k clears both the pending bit and the armed bit of kernel k.
- R5: A kernel whose ack mask is zero never completes.
- R6: fiq_o follows, one cycle later, the presence of a pending kernel whose enable bit in IE (0x04) is set. A pending kernel that is not enabled leaves fiq_o at 0.
- R7: In priority mode (CTRL 0x00 bit0 = 0), PEND bits [11:8] give the lowest-numbered enabled pending kernel and bit 15 flags that the field is valid. fiq_o stays high until every enabled pending bit has been cleared.
- R8: In parallel mode (CTRL bit0 = 1), fiq_o rises only once no enabled kernel is still armed.
- R9: Writing 1 to SLEEP (0x0C) bit0 sets sleep_o, and writing 0 clears it. An interrupt request clears sleep_o on the same edge that fiq_o rises.
- R10: Reads of unmapped or unaligned addresses return 0. Writes to them change nothing.
- R11: START reads back the armed bits at [16+k] and 0 in its start field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 16 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational on bus_addr_i |
| start_o | output | N_SLOT | Start request pulses |
| ack_i | input | N_SLOT | Unit acknowledgements |
| port_hs_i | input | N_PORT | Port handshake activity |
| fiq_o | output | 1 | Fast interrupt |
| sleep_o | output | 1 | Host sleep request |

## Verification
A corrupted sticky bit or mask shows up at PEND within two edges of the ack pulse: a kernel either completes when it should not, or never completes. Wrong priority state shows up as a wrong id field, or as fiq_o dropping while an enabled kernel is still pending. A broken parallel-mode gate raises fiq_o one cycle after the first kernel completes instead of the last. The sweeps cover every kernel slot, both with and without a port term, and with full, partial and zero ack masks.

// File: rtl/kirq_pkg.sv
package kirq_pkg;
  localparam logic [15:0] A_CTRL     = 16'h0000;
  localparam logic [15:0] A_IE       = 16'h0004;
  localparam logic [15:0] A_START    = 16'h0008;
  localparam logic [15:0] A_SLEEP    = 16'h000C;
  localparam logic [15:0] A_ACK_STS  = 16'h0010;
  localparam logic [15:0] A_PORT_STS = 16'h0014;
  localparam logic [15:0] A_PEND     = 16'h0018;
  localparam logic [15:0] A_MASK     = 16'h0040;
  localparam int unsigned ARM_LSB    = 16;
  localparam int unsigned ID_LSB     = 8;
  localparam int unsigned ID_VLD_BIT = 15;
endpackage

// File: rtl/kirq_sticky.sv
module kirq_sticky #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end

  assert_sticky_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/kirq_kernel.sv
module kirq_kernel #(
  parameter int unsigned N_SLOT = 10,
  parameter int unsigned N_PORT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              amask_we_i,
  input  logic              pmask_we_i,
  input  logic [31:0]       wdata_i,
  input  logic              arm_i,
  input  logic              abort_i,
  input  logic [N_SLOT-1:0] ack_s_i,
  input  logic [N_PORT-1:0] port_s_i,
  output logic [N_SLOT-1:0] amask_o,
  output logic [N_PORT-1:0] pmask_o,
  output logic              armed_o,
  output logic              pend_o
);
  logic acks_all, port_any, done;

  assign acks_all = (|amask_o) && ((ack_s_i & amask_o) == amask_o);
  assign port_any = (pmask_o == '0) || (|(port_s_i & pmask_o));
  assign done     = armed_o && acks_all && port_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amask_o <= '0;
      pmask_o <= '0;
      armed_o <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      if (amask_we_i) amask_o <= wdata_i[N_SLOT-1:0];
      if (pmask_we_i) pmask_o <= wdata_i[N_PORT-1:0];
      if (done)         armed_o <= 1'b0;
      else if (arm_i)   armed_o <= 1'b1;
      else if (abort_i) armed_o <= 1'b0;
      if (done)         pend_o <= 1'b1;
      else if (abort_i) pend_o <= 1'b0;
    end
  end

  assert_pend_needs_arm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(armed_o));
  assert_zero_mask_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(amask_o != '0));
endmodule

// File: rtl/kirq_resolve.sv
module kirq_resolve #(
  parameter int unsigned N_KERN = 4,
  localparam int unsigned KW = (N_KERN > 1) ? $clog2(N_KERN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_KERN-1:0] pend_i,
  input  logic [N_KERN-1:0] ie_i,
  input  logic [N_KERN-1:0] armed_i,
  input  logic              par_mode_i,
  output logic              irq_req_o,
  output logic              fiq_o,
  output logic [KW-1:0]     id_o,
  output logic              id_vld_o
);
  logic [N_KERN-1:0] pe;
  assign pe = pend_i & ie_i;

  always_comb begin
    id_o = '0;
    for (int i = N_KERN - 1; i >= 0; i--) begin
      if (pe[i]) id_o = KW'(i);
    end
  end
  assign id_vld_o  = |pe;
  assign irq_req_o = par_mode_i ? ((|pe) && !(|(armed_i & ie_i))) : (|pe);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fiq_o <= 1'b0;
    else         fiq_o <= irq_req_o;
  end

  assert_fiq_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> $past(|(pend_i & ie_i)));
  assert_par_wait_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_o && $past(par_mode_i)) |-> $past((armed_i & ie_i) == '0));
endmodule

// File: rtl/kernel_irq_ctrl.sv
module kernel_irq_ctrl
  import kirq_pkg::*;
#(
  parameter int unsigned N_SLOT = 10,
  parameter int unsigned N_PORT = 10,
  parameter int unsigned N_KERN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [15:0]       bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [N_SLOT-1:0] start_o,
  input  logic [N_SLOT-1:0] ack_i,
  input  logic [N_PORT-1:0] port_hs_i,
  output logic              fiq_o,
  output logic              sleep_o
);
  localparam int unsigned KW = (N_KERN > 1) ? $clog2(N_KERN) : 1;
  localparam logic [15:0] MASK_END = A_MASK + 16'(8 * N_KERN);

  logic              par_mode_q;
  logic [N_KERN-1:0] ie_q;
  logic [N_SLOT-1:0] ack_s;
  logic [N_PORT-1:0] port_s;
  logic [N_KERN-1:0] armed, pend;
  logic [N_SLOT-1:0] amask [N_KERN];
  logic [N_PORT-1:0] pmask [N_KERN];
  logic              irq_req, id_vld;
  logic [KW-1:0]     id;

  logic wr_ctrl, wr_ie, wr_start, wr_sleep, wr_ack, wr_port, wr_pend;
  logic in_mask;
  logic [15:0] moff;

  assign wr_ctrl  = bus_we_i && (bus_addr_i == A_CTRL);
  assign wr_ie    = bus_we_i && (bus_addr_i == A_IE);
  assign wr_start = bus_we_i && (bus_addr_i == A_START);
  assign wr_sleep = bus_we_i && (bus_addr_i == A_SLEEP);
  assign wr_ack   = bus_we_i && (bus_addr_i == A_ACK_STS);
  assign wr_port  = bus_we_i && (bus_addr_i == A_PORT_STS);
  assign wr_pend  = bus_we_i && (bus_addr_i == A_PEND);
  assign in_mask  = (bus_addr_i >= A_MASK) && (bus_addr_i < MASK_END) && (bus_addr_i[1:0] == 2'b00);
  assign moff     = bus_addr_i - A_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_mode_q <= 1'b0;
      ie_q       <= '0;
      start_o    <= '0;
      sleep_o    <= 1'b0;
    end else begin
      if (wr_ctrl) par_mode_q <= bus_wdata_i[0];
      if (wr_ie)   ie_q       <= bus_wdata_i[N_KERN-1:0];
      start_o <= wr_start ? bus_wdata_i[N_SLOT-1:0] : '0;
      if (irq_req)       sleep_o <= 1'b0;
      else if (wr_sleep) sleep_o <= bus_wdata_i[0];
    end
  end

  kirq_sticky #(.W(N_SLOT)) u_ack_sticky (
    .clk_i, .rst_ni, .set_i(ack_i),
    .clr_i(wr_ack ? bus_wdata_i[N_SLOT-1:0] : '0), .q_o(ack_s)
  );
  kirq_sticky #(.W(N_PORT)) u_port_sticky (
    .clk_i, .rst_ni, .set_i(port_hs_i),
    .clr_i(wr_port ? bus_wdata_i[N_PORT-1:0] : '0), .q_o(port_s)
  );

  for (genvar k = 0; k < N_KERN; k++) begin : g_kern
    logic sel;
    assign sel = in_mask && (moff[15:3] == 13'(k));
    kirq_kernel #(.N_SLOT(N_SLOT), .N_PORT(N_PORT)) u_kern (
      .clk_i, .rst_ni,
      .amask_we_i(bus_we_i && sel && !moff[2]),
      .pmask_we_i(bus_we_i && sel &&  moff[2]),
      .wdata_i   (bus_wdata_i),
      .arm_i     (wr_start && bus_wdata_i[ARM_LSB + k]),
      .abort_i   (wr_pend && bus_wdata_i[k]),
      .ack_s_i   (ack_s),
      .port_s_i  (port_s),
      .amask_o   (amask[k]),
      .pmask_o   (pmask[k]),
      .armed_o   (armed[k]),
      .pend_o    (pend[k])
    );
  end

  kirq_resolve #(.N_KERN(N_KERN)) u_resolve (
    .clk_i, .rst_ni,
    .pend_i(pend), .ie_i(ie_q), .armed_i(armed), .par_mode_i(par_mode_q),
    .irq_req_o(irq_req), .fiq_o(fiq_o), .id_o(id), .id_vld_o(id_vld)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (in_mask) begin
      for (int k = 0; k < N_KERN; k++) begin
        if (moff[15:3] == 13'(k)) begin
          if (moff[2]) bus_rdata_o[N_PORT-1:0] = pmask[k];
          else         bus_rdata_o[N_SLOT-1:0] = amask[k];
        end
      end
    end else begin
      case (bus_addr_i)
        A_CTRL:     bus_rdata_o[0] = par_mode_q;
        A_IE:       bus_rdata_o[N_KERN-1:0] = ie_q;
        A_START:    bus_rdata_o[ARM_LSB +: N_KERN] = armed;
        A_SLEEP:    bus_rdata_o[0] = sleep_o;
        A_ACK_STS:  bus_rdata_o[N_SLOT-1:0] = ack_s;
        A_PORT_STS: bus_rdata_o[N_PORT-1:0] = port_s;
        A_PEND: begin
          bus_rdata_o[N_KERN-1:0]     = pend;
          bus_rdata_o[ID_LSB +: KW]   = id;
          bus_rdata_o[ID_VLD_BIT]     = id_vld;
        end
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |-> $past(bus_we_i && (bus_addr_i == A_START)));
  assert_wake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> $past(irq_req || (wr_sleep && !bus_wdata_i[0])));
endmodule

// File: tb/kernel_irq_ctrl_bench.sv
`timescale 1ns/1ps
module kernel_irq_ctrl_bench;
  localparam int NS = 10, NP = 10, NK = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NS-1:0] start, ack = '0;
  logic [NP-1:0] port = '0;
  logic fiq, sleep;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  kernel_irq_ctrl #(.N_SLOT(NS), .N_PORT(NP), .N_KERN(NK)) u_kernel_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .start_o(start), .ack_i(ack),
    .port_hs_i(port), .fiq_o(fiq), .sleep_o(sleep)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [NS-1:0] a, input logic [NP-1:0] p);
    @(negedge clk); ack = a; port = p;
    @(negedge clk); ack = '0; port = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clean();
    wr(16'h0018, 32'hFFFF_FFFF);
    wr(16'h0010, 32'hFFFF_FFFF);
    wr(16'h0014, 32'hFFFF_FFFF);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NS-1:0] am, ap;
    logic [NP-1:0] pm, pp;
    logic exp_done;
    idle(3);
    // R1 reset values
    chk(32'(start), 0, "R1 start_o");
    chk(32'(fiq), 0, "R1 fiq_o");
    chk(32'(sleep), 0, "R1 sleep_o");
    rst_n = 1'b1;
    idle(1);
    rd(16'h0000, d); chk(d, 0, "R1 CTRL");
    rd(16'h0018, d); chk(d, 0, "R1 PEND");
    rd(16'h0010, d); chk(d, 0, "R1 ACK_STS");
    rd(16'h0008, d); chk(d, 0, "R1 START");

    // R2 start pulse lasts one cycle
    wr(16'h0008, 32'h0000_0281);
    chk(32'(start), 32'h281, "R2 start pulse high");
    @(negedge clk);
    chk(32'(start), 0, "R2 start pulse low");

    // R3 sticky status and write-1-to-clear
    pulse(10'h205, 10'h030);
    rd(16'h0010, d); chk(d, 32'h205, "R3 ack sticky");
    rd(16'h0014, d); chk(d, 32'h030, "R3 port sticky");
    wr(16'h0010, 32'h1);
    rd(16'h0010, d); chk(d, 32'h204, "R3 ack w1c");

    // R11 armed readback, R5 zero mask never completes
    clean();
    wr(16'h0008, 32'h0001_0000);
    rd(16'h0008, d); chk(d, 32'h0001_0000, "R11 armed readback");
    pulse('1, '1);
    idle(3);
    rd(16'h0018, d); chk(d, 0, "R5 zero mask stays idle");

    // R4/R5 sweep over kernels and mask patterns (IE off)
    wr(16'h0004, 0);
    for (int k = 0; k < NK; k++) begin
      for (int i = 0; i < 8; i++) begin
        am = (i == 0) ? '0 : NS'(((k * 37 + i * 113) % 1023) + 1);
        ap = (i == 0) ? '1 : (i[0] ? am : (am & (am - 1'b1)));
        pm = (i % 3 == 0) ? '0 : NP'(1 << ((i + k) % 10));
        pp = (i % 4 == 1) ? '0 : pm;
        exp_done = (am != 0) && ((ap & am) == am) && (pm == 0 || (pp & pm) != 0);
        clean();
        wr(16'(16'h0040 + 8 * k), 32'(am));
        wr(16'(16'h0044 + 8 * k), 32'(pm));
        wr(16'h0008, 32'(1) << (16 + k));
        pulse(ap, pp);
        idle(2);
        rd(16'h0018, d);
        chk(d & 32'hF, exp_done ? (32'(1) << k) : 0, $sformatf("R4 sweep k=%0d i=%0d", k, i));
      end
    end
    clean();

    // R6 disabled kernel leaves fiq low; enabling later raises it
    wr(16'h0058, 32'h100);
    wr(16'h005C, 0);
    wr(16'h0008, 32'h0008_0000);
    pulse(10'h100, '0);
    idle(3);
    chk(32'(fiq), 0, "R6 disabled no fiq");
    rd(16'h0018, d); chk(d, 32'h8, "R6 pending without id");
    wr(16'h0004, 32'h8);
    @(negedge clk);
    chk(32'(fiq), 1, "R6 enable raises fiq");
    clean();
    idle(2);

    // R7 priority + R9 wake
    wr(16'h0004, 32'hF);
    wr(16'h0048, 32'h002); wr(16'h004C, 0);
    wr(16'h0050, 32'h004); wr(16'h0054, 0);
    wr(16'h000C, 1);
    chk(32'(sleep), 1, "R9 sleep set");
    wr(16'h0008, 32'h0006_0000);
    pulse(10'h006, '0);
    @(negedge clk);
    chk(32'(fiq), 0, "R6 fiq one cycle after pending");
    chk(32'(sleep), 1, "R9 still asleep");
    @(negedge clk);
    chk(32'(fiq), 1, "R7 fiq raised");
    chk(32'(sleep), 0, "R9 wake with fiq");
    rd(16'h0018, d); chk(d, 32'h8106, "R7 id lowest kernel");
    wr(16'h0018, 32'h2);
    @(negedge clk);
    chk(32'(fiq), 1, "R7 fiq held for kernel 2");
    rd(16'h0018, d); chk(d, 32'h8204, "R7 id next kernel");
    wr(16'h0018, 32'h4);
    @(negedge clk);
    chk(32'(fiq), 0, "R7 fiq cleared");
    wr(16'h000C, 1); wr(16'h000C, 0);
    chk(32'(sleep), 0, "R9 sleep cleared by write");

    // R8 parallel mode
    clean();
    wr(16'h0000, 1);
    wr(16'h0004, 32'h3);
    wr(16'h0040, 32'h001); wr(16'h0044, 0);
    wr(16'h0048, 32'h002); wr(16'h004C, 0);
    wr(16'h0008, 32'h0003_0000);
    pulse(10'h001, '0);
    idle(3);
    chk(32'(fiq), 0, "R8 waits for all kernels");
    rd(16'h0018, d); chk(d & 32'hF, 32'h1, "R8 first pending");
    pulse(10'h002, '0);
    idle(2);
    chk(32'(fiq), 1, "R8 fiq after last kernel");
    clean();
    wr(16'h0000, 0);

    // R10 unmapped
    wr(16'h001C, 32'hFFFF_FFFF);
    wr(16'h0060, 32'hFFFF_FFFF);
    wr(16'h0006, 32'hFFFF_FFFF);
    rd(16'h001C, d); chk(d, 0, "R10 unmapped 0x1C");
    rd(16'h0060, d); chk(d, 0, "R10 unmapped 0x60");
    rd(16'h0002, d); chk(d, 0, "R10 unaligned read");
    rd(16'h0004, d); chk(d, 32'h3, "R10 IE unchanged");
    rd(16'h0000, d); chk(d, 0, "R10 CTRL unchanged");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule